// File: doc/BRIEF.md
# Encrypted key load sequencer

This block governs how a cipher key reaches one of two crypto-context register sets. A host writes a single-DES or triple-DES key into a chosen context together with a black/red flag. A red (plaintext) key is stored at once, provided the red-key permit configuration input allows plaintext keys. A black (encrypted) key is stored as written and then decrypted in place. The block runs CBC decryption under a write-only key-encryption key, with the context's stored salt as the initial chaining value. Each 64-bit key block is handed to a shared cipher engine through a request/done handshake.

Each context carries a key-valid flag. Packet processing for a context is released only while that flag is set, so packet data may be queued before the key is ready. A context whose key is already valid is reused for later packets with no further engine traffic. While one context is being decrypted, the other context keeps serving packets.

The controller has three states. `KS_IDLE` waits for a black key write and moves to `KS_ISSUE`. `KS_ISSUE` holds the engine request until done, captures the engine output and moves to `KS_MERGE`. `KS_MERGE` XORs that output with the chaining value and writes the plaintext block back. It then returns to `KS_ISSUE` for the next block, or to `KS_IDLE` after the last block, when it also sets key-valid.

Top module: `keyload_seq`

## Requirements
- R1: After reset `key_valid` is all zero, `err`, `busy`, `eng_req` and `proc_go` are 0, and `eng_key` is zero.
- R2: A key write while idle with `key_black`=0 and `red_permit`=1 stores the key in the selected context and sets its `key_valid` on the next cycle. No engine request is made. For a single-DES key (`key_triple`=0) only bits [63:0] are kept and bits [191:64] read as zero.
- R3: A key write while idle with `key_black`=0 and `red_permit`=0 leaves that context's key and `key_valid` unchanged and sets `err` on the next cycle. `err` then stays set until a cycle with `err_clr`=1 and no new rejection.
- R4: A key write while idle with `key_black`=1 clears the context's `key_valid` and raises `busy` on the next cycle. Decryption makes one engine request per key block: one for single-DES, three for triple-DES. Block i is key bits [64i+63:64i]. The stored result is P_i = dout_i XOR C_(i-1), with C_(-1) being the context salt.
- R5: During a request, `eng_key` carries the full 192-bit key-encryption key for a triple-DES key. For a single-DES key it carries the key-encryption key's bits [63:0] with the upper bits zero. `eng_triple` gives the key type, and `eng_din` is the ciphertext block.
- R6: `eng_req` stays high until `eng_done` is sampled high, is low in the following cycle, and is never high while `busy` is 0.
- R7: `proc_go` is high exactly when `proc_req` is high and the context named by `proc_sel` has `key_valid` set.
- R8: Repeated packet requests on a context with a valid key cause no engine requests.
- R9: A key write made while `busy` is 1 is ignored: no context key, `key_valid` or `err` changes because of it.
- R10: While one context is being decrypted, `proc_go` for the other valid context is still granted.
- R11: The key-encryption key can only be written. `eng_key` is zero whenever `eng_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| red_permit | input | 1 | Configuration: 1 allows plaintext key loads |
| kek_we | input | 1 | Key-encryption key write strobe |
| kek_wdata | input | 192 | Key-encryption key write data |
| salt_we | input | 1 | Salt write strobe |
| salt_sel | input | 1 | Context receiving the salt |
| salt_wdata | input | 64 | Salt value |
| key_we | input | 1 | Key write strobe |
| key_sel | input | 1 | Context receiving the key |
| key_black | input | 1 | 1: key is encrypted and must be decrypted |
| key_triple | input | 1 | 1: triple-DES key, 0: single-DES key |
| key_wdata | input | 192 | Key data |
| err_clr | input | 1 | Clears the sticky rejection flag |
| err | output | 1 | Sticky plaintext-key rejection flag |
| busy | output | 1 | Decryption in progress |
| key_valid | output | 2 | Per-context key-ready flags |
| key_rd_sel | input | 1 | Context whose key the datapath reads |
| key_rd_data | output | 192 | Stored key of `key_rd_sel` |
| proc_req | input | 1 | Packet processing wants to start |
| proc_sel | input | 1 | Context used by that packet |
| proc_go | output | 1 | Packet processing released |
| eng_req | output | 1 | Cipher engine request |
| eng_triple | output | 1 | Engine mode: triple-DES when 1 |
| eng_key | output | 192 | Engine key (key-encryption key) |
| eng_din | output | 64 | Ciphertext block to decrypt |
| eng_done | input | 1 | Engine result valid, one-cycle pulse |
| eng_dout | input | 64 | Raw block decryption result |

## Verification
The assertions assume that the engine raises `eng_done` only while `eng_req` is high, as a single-cycle pulse, and that `eng_dout` is valid in that cycle. The bench's engine model answers each request after a fixed delay of 6 cycles per single-DES block or 12 per triple-DES block, and checks the key and mode it was given. Random key writes are issued only while the block is idle, with random context, type, black flag and permit. The busy-time write is a deliberate directed case, so the bench's expected contexts stay exact.

// File: rtl/keyload_pkg.sv
package keyload_pkg;
    typedef enum logic [1:0] {
        KS_IDLE  = 2'd0,
        KS_ISSUE = 2'd1,
        KS_MERGE = 2'd2
    } kseq_state_e;
endpackage

// File: rtl/keyload_kek.sv
module keyload_kek #(
    parameter int KEY_W = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [KEY_W-1:0] wdata,
    output logic [KEY_W-1:0] kek
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kek <= '0;
        end else if (we) begin
            kek <= wdata;
        end
    end
endmodule

// File: rtl/keyload_ctx_bank.sv
module keyload_ctx_bank #(
    parameter int BLK_W = 64,
    parameter int NBLK  = 3,
    parameter int NCTX  = 2,
    localparam int KEY_W = BLK_W * NBLK,
    localparam int SEL_W = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_we,
    input  logic [SEL_W-1:0]            host_sel,
    input  logic [KEY_W-1:0]            host_data,
    input  logic                        host_valid,
    input  logic                        salt_we,
    input  logic [SEL_W-1:0]            salt_sel,
    input  logic [BLK_W-1:0]            salt_wdata,
    input  logic                        blk_we,
    input  logic [SEL_W-1:0]            blk_sel,
    input  logic [IDX_W-1:0]            blk_idx,
    input  logic [BLK_W-1:0]            blk_data,
    input  logic                        valid_set,
    output logic [NCTX-1:0][KEY_W-1:0]  key_all,
    output logic [NCTX-1:0][BLK_W-1:0]  salt_all,
    output logic [NCTX-1:0]             valid_all
);
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        logic hit_host;
        logic hit_blk;
        logic hit_salt;

        assign hit_host = host_we && (int'(host_sel) == c);
        assign hit_blk  = blk_we && (int'(blk_sel) == c);
        assign hit_salt = salt_we && (int'(salt_sel) == c);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                key_all[c]   <= '0;
                valid_all[c] <= 1'b0;
            end else if (hit_host) begin
                key_all[c]   <= host_data;
                valid_all[c] <= host_valid;
            end else begin
                if (hit_blk) begin
                    key_all[c][int'(blk_idx)*BLK_W +: BLK_W] <= blk_data;
                end
                if (valid_set && (int'(blk_sel) == c)) begin
                    valid_all[c] <= 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                salt_all[c] <= '0;
            end else if (hit_salt) begin
                salt_all[c] <= salt_wdata;
            end
        end
    end
endmodule

// File: rtl/keyload_cbc_fsm.sv
module keyload_cbc_fsm
    import keyload_pkg::*;
#(
    parameter int BLK_W = 64,
    parameter int NBLK  = 3,
    parameter int NCTX  = 2,
    localparam int SEL_W = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEL_W-1:0] start_sel,
    input  logic             start_triple,
    input  logic [BLK_W-1:0] start_iv,
    input  logic [BLK_W-1:0] cur_blk,
    input  logic             eng_done,
    input  logic [BLK_W-1:0] eng_dout,
    output logic             busy,
    output logic [SEL_W-1:0] tgt,
    output logic [IDX_W-1:0] idx,
    output logic             triple,
    output logic             eng_req,
    output logic [BLK_W-1:0] eng_din,
    output logic             blk_we,
    output logic [BLK_W-1:0] blk_data,
    output logic             valid_set
);
    kseq_state_e      state_q, state_d;
    logic [BLK_W-1:0] chain_q;
    logic [BLK_W-1:0] dout_q;
    logic [IDX_W-1:0] last_idx;
    logic             at_last;

    assign last_idx = triple ? IDX_W'(NBLK - 1) : '0;
    assign at_last  = (idx == last_idx);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_IDLE:  if (start)    state_d = KS_ISSUE;
            KS_ISSUE: if (eng_done) state_d = KS_MERGE;
            KS_MERGE: state_d = at_last ? KS_IDLE : KS_ISSUE;
            default:  state_d = KS_IDLE;
        endcase
    end

    // Working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt     <= '0;
            triple  <= 1'b0;
            idx     <= '0;
            chain_q <= '0;
            dout_q  <= '0;
        end else begin
            unique case (state_q)
                KS_IDLE: begin
                    if (start) begin
                        tgt     <= start_sel;
                        triple  <= start_triple;
                        idx     <= '0;
                        chain_q <= start_iv;
                    end
                end
                KS_ISSUE: begin
                    if (eng_done) begin
                        dout_q <= eng_dout;
                    end
                end
                KS_MERGE: begin
                    chain_q <= cur_blk;
                    if (!at_last) begin
                        idx <= idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != KS_IDLE);
        eng_req   = 1'b0;
        blk_we    = 1'b0;
        valid_set = 1'b0;
        eng_din   = '0;
        blk_data  = dout_q ^ chain_q;
        unique case (state_q)
            KS_IDLE:  ;
            KS_ISSUE: begin
                eng_req = 1'b1;
                eng_din = cur_blk;
            end
            KS_MERGE: begin
                blk_we    = 1'b1;
                valid_set = at_last;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/keyload_seq.sv
module keyload_seq #(
    parameter int BLK_W = 64,
    parameter int NBLK  = 3,
    parameter int NCTX  = 2,
    localparam int KEY_W = BLK_W * NBLK,
    localparam int SEL_W = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             red_permit,
    input  logic             kek_we,
    input  logic [KEY_W-1:0] kek_wdata,
    input  logic             salt_we,
    input  logic [SEL_W-1:0] salt_sel,
    input  logic [BLK_W-1:0] salt_wdata,
    input  logic             key_we,
    input  logic [SEL_W-1:0] key_sel,
    input  logic             key_black,
    input  logic             key_triple,
    input  logic [KEY_W-1:0] key_wdata,
    input  logic             err_clr,
    output logic             err,
    output logic             busy,
    output logic [NCTX-1:0]  key_valid,
    input  logic [SEL_W-1:0] key_rd_sel,
    output logic [KEY_W-1:0] key_rd_data,
    input  logic             proc_req,
    input  logic [SEL_W-1:0] proc_sel,
    output logic             proc_go,
    output logic             eng_req,
    output logic             eng_triple,
    output logic [KEY_W-1:0] eng_key,
    output logic [BLK_W-1:0] eng_din,
    input  logic             eng_done,
    input  logic [BLK_W-1:0] eng_dout
);
    logic [KEY_W-1:0]            kek_q;
    logic [NCTX-1:0][KEY_W-1:0]  key_all;
    logic [NCTX-1:0][BLK_W-1:0]  salt_all;
    logic                        wr_ok, reject, host_we, start;
    logic [KEY_W-1:0]            host_data;
    logic [SEL_W-1:0]            tgt;
    logic [IDX_W-1:0]            idx;
    logic                        blk_we, valid_set;
    logic [BLK_W-1:0]            blk_data, cur_blk;

    assign wr_ok     = key_we && !busy;
    assign reject    = wr_ok && !key_black && !red_permit;
    assign host_we   = wr_ok && (key_black || red_permit);
    assign start     = host_we && key_black;
    assign host_data = key_triple ? key_wdata : KEY_W'(key_wdata[BLK_W-1:0]);
    assign cur_blk   = key_all[tgt][int'(idx)*BLK_W +: BLK_W];

    keyload_kek #(.KEY_W(KEY_W)) u_kek (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (kek_we),
        .wdata (kek_wdata),
        .kek   (kek_q)
    );

    keyload_ctx_bank #(.BLK_W(BLK_W), .NBLK(NBLK), .NCTX(NCTX)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_sel   (key_sel),
        .host_data  (host_data),
        .host_valid (!key_black),
        .salt_we    (salt_we),
        .salt_sel   (salt_sel),
        .salt_wdata (salt_wdata),
        .blk_we     (blk_we),
        .blk_sel    (tgt),
        .blk_idx    (idx),
        .blk_data   (blk_data),
        .valid_set  (valid_set),
        .key_all    (key_all),
        .salt_all   (salt_all),
        .valid_all  (key_valid)
    );

    keyload_cbc_fsm #(.BLK_W(BLK_W), .NBLK(NBLK), .NCTX(NCTX)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_sel    (key_sel),
        .start_triple (key_triple),
        .start_iv     (salt_all[key_sel]),
        .cur_blk      (cur_blk),
        .eng_done     (eng_done),
        .eng_dout     (eng_dout),
        .busy         (busy),
        .tgt          (tgt),
        .idx          (idx),
        .triple       (eng_triple),
        .eng_req      (eng_req),
        .eng_din      (eng_din),
        .blk_we       (blk_we),
        .blk_data     (blk_data),
        .valid_set    (valid_set)
    );

    // Key-encryption key leaves the block only during a request
    always_comb begin
        eng_key = '0;
        if (eng_req) begin
            eng_key = eng_triple ? kek_q : KEY_W'(kek_q[BLK_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (reject) begin
            err <= 1'b1;
        end else if (err_clr) begin
            err <= 1'b0;
        end
    end

    assign proc_go     = proc_req && key_valid[proc_sel];
    assign key_rd_data = key_all[key_rd_sel];
endmodule

// File: rtl/keyload_seq_chk.sv
module keyload_seq_chk #(
    parameter int NCTX  = 2,
    parameter int KEY_W = 192,
    parameter int SEL_W = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             red_permit,
    input logic             key_we,
    input logic [SEL_W-1:0] key_sel,
    input logic             key_black,
    input logic             err,
    input logic             err_clr,
    input logic             busy,
    input logic [NCTX-1:0]  key_valid,
    input logic             eng_req,
    input logic             eng_done,
    input logic [KEY_W-1:0] eng_key
);
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_done |=> eng_req);

    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && eng_done |=> !eng_req);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !eng_req);

    assert_kek_hidden_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_req |-> (eng_key == '0));

    assert_reject_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        key_we && !busy && !key_black && !red_permit |=> err);

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err && !err_clr |=> err);

    assert_black_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        key_we && !busy && key_black |=> busy && !key_valid[$past(key_sel)]);
endmodule

bind keyload_seq keyload_seq_chk #(.NCTX(NCTX), .KEY_W(KEY_W), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .red_permit (red_permit),
    .key_we     (key_we),
    .key_sel    (key_sel),
    .key_black  (key_black),
    .err        (err),
    .err_clr    (err_clr),
    .busy       (busy),
    .key_valid  (key_valid),
    .eng_req    (eng_req),
    .eng_done   (eng_done),
    .eng_key    (eng_key)
);

// File: tb/keyload_seq_test.sv
`timescale 1ns/1ps
module keyload_seq_test;
    localparam int BW = 64;
    localparam int KW = 192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          red_permit = 0, kek_we = 0, salt_we = 0, key_we = 0;
    logic          salt_sel = 0, key_sel = 0, key_black = 0, key_triple = 0;
    logic [KW-1:0] kek_wdata = '0, key_wdata = '0;
    logic [BW-1:0] salt_wdata = '0;
    logic          err_clr = 0, key_rd_sel = 0, proc_req = 0, proc_sel = 0;
    logic          err, busy, proc_go, eng_req, eng_triple;
    logic [1:0]    key_valid;
    logic [KW-1:0] key_rd_data, eng_key;
    logic [BW-1:0] eng_din;
    logic          eng_done = 0;
    logic [BW-1:0] eng_dout = '0;

    keyload_seq uut (
        .clk(clk), .rst_n(rst_n), .red_permit(red_permit),
        .kek_we(kek_we), .kek_wdata(kek_wdata),
        .salt_we(salt_we), .salt_sel(salt_sel), .salt_wdata(salt_wdata),
        .key_we(key_we), .key_sel(key_sel), .key_black(key_black),
        .key_triple(key_triple), .key_wdata(key_wdata),
        .err_clr(err_clr), .err(err), .busy(busy), .key_valid(key_valid),
        .key_rd_sel(key_rd_sel), .key_rd_data(key_rd_data),
        .proc_req(proc_req), .proc_sel(proc_sel), .proc_go(proc_go),
        .eng_req(eng_req), .eng_triple(eng_triple), .eng_key(eng_key),
        .eng_din(eng_din), .eng_done(eng_done), .eng_dout(eng_dout)
    );

    int checks = 0, fails = 0, req_count = 0;
    logic [KW-1:0] m_kek = '0;
    logic [BW-1:0] m_salt [2];
    logic [KW-1:0] m_key [2];
    logic          m_valid [2];
    logic          m_err = 0;
    logic          m_triple = 0;

    task automatic chk(input bit ok, input string tag, input logic [KW-1:0] act, input logic [KW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] eng_f(input logic [BW-1:0] d, input logic [KW-1:0] k);
        return {d[55:0], d[63:56]} ^ k[63:0] ^ {k[95:64], k[127:96]} ^ k[191:128] ^ 64'hC3A5_5A3C_0F1E_E1F0;
    endfunction

    function automatic logic [KW-1:0] use_key(input logic trip);
        return trip ? m_kek : KW'(m_kek[BW-1:0]);
    endfunction

    function automatic logic [KW-1:0] exp_black(input logic [KW-1:0] ct, input logic [BW-1:0] iv, input logic trip);
        logic [KW-1:0] r = '0;
        logic [BW-1:0] prev = iv;
        for (int i = 0; i < (trip ? 3 : 1); i++) begin
            r[i*BW +: BW] = eng_f(ct[i*BW +: BW], use_key(trip)) ^ prev;
            prev = ct[i*BW +: BW];
        end
        return r;
    endfunction

    // Engine model: fixed latency, checks key and handshake (R5, R6)
    logic [BW-1:0] e_din;
    logic [KW-1:0] e_key;
    always begin
        @(negedge clk);
        if (eng_req && !eng_done) begin
            req_count++;
            e_din = eng_din;
            e_key = eng_key;
            chk(eng_key == use_key(m_triple), "R5 engine key", eng_key, use_key(m_triple));
            chk(eng_triple == m_triple, "R5 engine mode", KW'(eng_triple), KW'(m_triple));
            repeat ((m_triple ? 12 : 6) - 1) begin
                @(negedge clk);
                chk(eng_req == 1'b1, "R6 request held", KW'(eng_req), KW'(1));
            end
            eng_dout = eng_f(e_din, e_key);
            eng_done = 1'b1;
            @(negedge clk);
            eng_done = 1'b0;
            chk(eng_req == 1'b0, "R6 request dropped after done", KW'(eng_req), KW'(0));
        end
    end

    task automatic write_key(input logic sel, input logic [KW-1:0] d, input logic trip, input logic blk);
        logic [KW-1:0] md = trip ? d : KW'(d[BW-1:0]);
        if (!busy) begin
            if (blk) begin
                m_key[sel] = exp_black(md, m_salt[sel], trip);
                m_valid[sel] = 1'b1;
                m_triple = trip;
            end else if (red_permit) begin
                m_key[sel] = md;
                m_valid[sel] = 1'b1;
            end else begin
                m_err = 1'b1;
            end
        end
        key_we = 1; key_sel = sel; key_wdata = d; key_triple = trip; key_black = blk;
        @(negedge clk);
        key_we = 0;
    endtask

    task automatic write_salt(input logic sel, input logic [BW-1:0] v);
        salt_we = 1; salt_sel = sel; salt_wdata = v; m_salt[sel] = v;
        @(negedge clk);
        salt_we = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy, "R4 decryption finishes", KW'(busy), KW'(0));
    endtask

    task automatic compare_all(input string tag);
        for (int c = 0; c < 2; c++) begin
            key_rd_sel = c[0];
            #0.5;
            chk(key_rd_data == m_key[c], {tag, " key"}, key_rd_data, m_key[c]);
            chk(key_valid[c] == m_valid[c], {tag, " valid"}, KW'(key_valid[c]), KW'(m_valid[c]));
        end
        chk(err == m_err, {tag, " err"}, KW'(err), KW'(m_err));
    endtask

    logic [KW-1:0] rk;
    int rc;

    initial begin
        void'($urandom(32'd7331));
        m_salt[0] = '0; m_salt[1] = '0; m_key[0] = '0; m_key[1] = '0;
        m_valid[0] = 0; m_valid[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        proc_req = 1;
        #0.5;
        // R1 reset state
        chk(key_valid == 2'b00, "R1 key_valid", KW'(key_valid), KW'(0));
        chk(!err && !busy && !eng_req && !proc_go, "R1 flags", KW'({err, busy, eng_req, proc_go}), KW'(0));
        chk(eng_key == '0, "R11 key hidden at reset", eng_key, '0);
        proc_req = 0;
        @(negedge clk);

        m_kek = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        kek_we = 1; kek_wdata = m_kek; @(negedge clk); kek_we = 0;
        write_salt(0, {$urandom, $urandom});
        write_salt(1, {$urandom, $urandom});

        // R2 plaintext keys
        red_permit = 1;
        rc = req_count;
        write_key(0, {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom}, 0, 0);
        compare_all("R2 red single-DES");
        write_key(1, {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom}, 1, 0);
        compare_all("R2 red triple-DES");
        chk(req_count == rc, "R2 no engine request", KW'(req_count), KW'(rc));

        // R4 black single key on ctx0, R7/R10 gating, R9 busy write
        rc = req_count;
        write_key(0, {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom}, 0, 1);
        chk(busy && !key_valid[0], "R4 busy and invalid after black write", KW'({busy, key_valid[0]}), KW'(2'b10));
        proc_req = 1; proc_sel = 0; #0.5;
        chk(proc_go == 1'b0, "R7 packet held while key pending", KW'(proc_go), KW'(0));
        proc_sel = 1; #0.5;
        chk(proc_go == 1'b1, "R10 other context proceeds", KW'(proc_go), KW'(1));
        proc_req = 0;
        @(negedge clk);
        write_key(1, {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom}, 1, 1);
        wait_idle();
        compare_all("R9 busy write ignored / R4 single");
        chk(req_count - rc == 1, "R4 one block request", KW'(req_count - rc), KW'(1));
        proc_req = 1; proc_sel = 0; #0.5;
        chk(proc_go == 1'b1, "R7 packet released", KW'(proc_go), KW'(1));
        proc_req = 0;
        @(negedge clk);

        // R4 black triple key on ctx1
        rc = req_count;
        write_key(1, {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom}, 1, 1);
        wait_idle();
        compare_all("R4 black triple-DES");
        chk(req_count - rc == 3, "R4 three block requests", KW'(req_count - rc), KW'(3));

        // R8 reuse without re-decryption
        rc = req_count;
        for (int i = 0; i < 20; i++) begin
            proc_req = i[0]; proc_sel = i[1];
            @(negedge clk);
        end
        proc_req = 0;
        chk(req_count == rc, "R8 reuse issues no request", KW'(req_count), KW'(rc));

        // R3 directed rejection and clear
        red_permit = 0;
        write_key(0, {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom}, 1, 0);
        compare_all("R3 red key rejected");
        err_clr = 1; m_err = 0; @(negedge clk); err_clr = 0;
        compare_all("R3 err cleared");

        // Random mix (R2, R3, R4)
        for (int i = 0; i < 30; i++) begin
            red_permit = $urandom_range(0, 1);
            rk = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            if ($urandom_range(0, 3) == 0) write_salt($urandom_range(0, 1), {$urandom, $urandom});
            write_key($urandom_range(0, 1), rk, $urandom_range(0, 1), $urandom_range(0, 1));
            wait_idle();
            #0.5;
            chk(eng_key == '0, "R11 key hidden when idle", eng_key, '0);
            compare_all("R4 random mix");
            if ($urandom_range(0, 2) == 0) begin
                err_clr = 1; m_err = 0; @(negedge clk); err_clr = 0;
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired (R4) actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule